// File: doc/BRIEF.md
# Instruction Field Decode and Cycle Sequencer

This block sits at the front of a small accumulator-style microcontroller core. Each 14-bit instruction word is sorted into one of four formats: byte-oriented, bit-oriented, literal/control or long jump. The block pulls out the operand fields for that format and states where the result goes, either the working register or the addressed file register. It then holds that decoded view steady for a whole instruction cycle of four clock phases.

The core's control logic raises `redirect` when an instruction changes the program counter or its conditional test comes out true. The word fetched next is then not executed. For that one instruction cycle the block presents an empty slot (a no-operation) and raises `flush`. After that cycle it goes back to normal decoding on its own.

Top module: `insn_front`

## Requirements
- R1: `phase` advances by one on every clock edge out of reset, taking the values 0, 1, 2, 3 and then wrapping to 0.
- R2: The decoded outputs and `flush` change only on the clock edge where `phase` is 3. They hold their values through phases 0 to 2 of the new cycle.
- R3: `fmt` encodes the format as 0 for the empty slot. For the other formats it follows word bits 13:12: 00 gives 1 (byte), 01 gives 2 (bit), 10 gives 4 (long jump) and 11 gives 3 (literal/control).
- R4: For a byte word, `opcode` is bits 13:8, `dest_file` is bit 7 (0 = working register, 1 = file register) and `file_addr` is bits 6:0. `bit_sel` and `imm` are 0.
- R5: For a bit word, `opcode` is {00, bits 13:10}, `bit_sel` is bits 9:7, `file_addr` is bits 6:0 and `dest_file` is 1. `imm` is 0.
- R6: For a literal word, `opcode` is bits 13:8 and `imm` is {000, bits 7:0}. `file_addr`, `bit_sel` and `dest_file` are 0.
- R7: For a long-jump word, `opcode` is {000, bits 13:11} and `imm` is bits 10:0. `file_addr`, `bit_sel` and `dest_file` are 0.
- R8: If `redirect` is 1 at the phase-3 edge, the cycle that follows shows `flush` = 1 and the empty slot: `fmt`, `opcode`, `file_addr`, `bit_sel`, `imm` and `dest_file` are all 0. This lasts exactly one cycle. The cycle after it decodes the word that is presented at that point.
- R9: `redirect` has no effect at the edges where `phase` is 0, 1 or 2.
- R10: A `redirect` at the phase-3 edge that ends a flushed cycle is ignored, so no second empty slot follows.
- R11: While synchronous reset `rst` is 1, the next edge sets `phase` to 0, `flush` to 0 and the outputs to the empty slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per edge |
| rst | input | 1 | Synchronous reset, active high |
| insn_word | input | 14 | Fetched instruction word, captured at the phase-3 edge |
| redirect | input | 1 | Program counter changed or skip taken, sampled at the phase-3 edge |
| phase | output | 2 | Phase within the instruction cycle |
| fmt | output | 3 | Format tag (0 empty, 1 byte, 2 bit, 3 literal, 4 long jump) |
| opcode | output | 6 | Opcode field, right-aligned |
| file_addr | output | 7 | File register address |
| bit_sel | output | 3 | Bit number within the file register |
| imm | output | 11 | Immediate value, right-aligned |
| dest_file | output | 1 | 1 = write back to file register, 0 = working register |
| flush | output | 1 | Current cycle is an empty slot |

## Verification
A phase counter that slips shows up on the very next edge. It also moves the capture point, so the decoded outputs change mid-cycle, within four clocks. A flush flag that sticks or re-arms produces a second empty slot, which is visible one instruction cycle after the first. A wrong field slice appears in the cycle right after the affected word is captured. Random words are mixed with random redirect pulses, so every format is covered, and so are flushes that land next to each other.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int WORD_W   = 14;
  localparam int OPC_W    = 6;
  localparam int FILE_W   = 7;
  localparam int BITSEL_W = 3;
  localparam int IMM_W    = 11;

  typedef enum logic [2:0] {
    FMT_NOP  = 3'd0,
    FMT_BYTE = 3'd1,
    FMT_BIT  = 3'd2,
    FMT_LIT  = 3'd3,
    FMT_JUMP = 3'd4
  } fmt_e;

  typedef struct packed {
    fmt_e                fmt;
    logic [OPC_W-1:0]    opc;
    logic [FILE_W-1:0]   file;
    logic [BITSEL_W-1:0] bsel;
    logic [IMM_W-1:0]    imm;
    logic                dest_file;
  } dec_t;

  function automatic dec_t empty_slot();
    dec_t d;
    d = '0;
    return d;
  endfunction

  // Format is picked by the top two bits; each format slices its own fields.
  function automatic dec_t decode_word(logic [WORD_W-1:0] w);
    dec_t d;
    d = '0;
    case (w[13:12])
      2'b00: begin
        d.fmt       = FMT_BYTE;
        d.opc       = w[13:8];
        d.dest_file = w[7];
        d.file      = w[6:0];
      end
      2'b01: begin
        d.fmt       = FMT_BIT;
        d.opc       = {2'b00, w[13:10]};
        d.bsel      = w[9:7];
        d.file      = w[6:0];
        d.dest_file = 1'b1;
      end
      2'b10: begin
        d.fmt = FMT_JUMP;
        d.opc = {3'b000, w[13:11]};
        d.imm = w[10:0];
      end
      default: begin
        d.fmt = FMT_LIT;
        d.opc = w[13:8];
        d.imm = {3'b000, w[7:0]};
      end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/ifd_phase_seq.sv
module ifd_phase_seq #(
  parameter int PHASES = 4,
  localparam int PH_W = $clog2(PHASES)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase,
  output logic            cycle_end
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

  always_ff @(posedge clk) begin
    if (rst)                phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + 1'b1;
  end

  assign cycle_end = (phase == LAST);

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (phase != LAST) |=> (phase == PH_W'($past(phase) + 1'b1))); // R1
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    cycle_end |=> (phase == '0)); // R1
endmodule

// File: rtl/ifd_field_decode.sv
module ifd_field_decode
  import ifd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dec_t              dec
);
  always_comb dec = decode_word(word);

  always_comb begin
    AST_WRITEBACK_SRC: assert (dec.dest_file == 1'b0 || dec.fmt == FMT_BYTE || dec.fmt == FMT_BIT); // R6
  end
endmodule

// File: rtl/ifd_issue_reg.sv
module ifd_issue_reg
  import ifd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cycle_end,
  input  logic redirect,
  input  dec_t dec_in,
  output dec_t dec_q,
  output logic flush_q
);
  // A redirect arms the empty slot, but never while a slot is already empty.
  logic take_redirect;
  assign take_redirect = cycle_end && redirect && !flush_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q   <= empty_slot();
      flush_q <= 1'b0;
    end else if (cycle_end) begin
      dec_q   <= take_redirect ? empty_slot() : dec_in;
      flush_q <= take_redirect;
    end
  end

  AST_FLUSH_ARMS: assert property (@(posedge clk) disable iff (rst)
    (cycle_end && redirect && !flush_q) |=> (flush_q && dec_q.fmt == FMT_NOP)); // R8
  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (cycle_end && flush_q) |=> !flush_q); // R10
  AST_HOLD_MIDCYCLE: assert property (@(posedge clk) disable iff (rst)
    !cycle_end |=> ($stable(dec_q) && $stable(flush_q))); // R2
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush_q |-> (dec_q == '0)); // R8
endmodule

// File: rtl/insn_front.sv
module insn_front
  import ifd_pkg::*;
#(
  parameter int PHASES = 4,
  localparam int PH_W = $clog2(PHASES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [WORD_W-1:0]   insn_word,
  input  logic                redirect,
  output logic [PH_W-1:0]     phase,
  output logic [2:0]          fmt,
  output logic [OPC_W-1:0]    opcode,
  output logic [FILE_W-1:0]   file_addr,
  output logic [BITSEL_W-1:0] bit_sel,
  output logic [IMM_W-1:0]    imm,
  output logic                dest_file,
  output logic                flush
);
  logic cycle_end;
  dec_t dec_next;
  dec_t dec_q;

  ifd_phase_seq #(.PHASES(PHASES)) i_seq (
    .clk(clk), .rst(rst), .phase(phase), .cycle_end(cycle_end)
  );

  ifd_field_decode i_dec (.word(insn_word), .dec(dec_next));

  ifd_issue_reg i_issue (
    .clk(clk), .rst(rst), .cycle_end(cycle_end), .redirect(redirect),
    .dec_in(dec_next), .dec_q(dec_q), .flush_q(flush)
  );

  assign fmt       = dec_q.fmt;
  assign opcode    = dec_q.opc;
  assign file_addr = dec_q.file;
  assign bit_sel   = dec_q.bsel;
  assign imm       = dec_q.imm;
  assign dest_file = dec_q.dest_file;

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (phase == '0 && !flush && fmt == 3'd0)); // R11
endmodule

// File: tb/test_insn_front.sv
module test_insn_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] insn_word = '0;
  logic        redirect = 1'b0;
  logic [1:0]  phase;
  logic [2:0]  fmt;
  logic [5:0]  opcode;
  logic [6:0]  file_addr;
  logic [2:0]  bit_sel;
  logic [10:0] imm;
  logic        dest_file;
  logic        flush;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int f, o, a, b, i, d;
  } exp_t;

  exp_t m_dec;
  int   m_ph = 0;
  bit   m_flush = 1'b0;
  string ctx = "";

  always #4 clk = ~clk;

  insn_front i_insn_front (
    .clk(clk), .rst(rst), .insn_word(insn_word), .redirect(redirect),
    .phase(phase), .fmt(fmt), .opcode(opcode), .file_addr(file_addr),
    .bit_sel(bit_sel), .imm(imm), .dest_file(dest_file), .flush(flush)
  );

  function automatic exp_t empty_exp();
    exp_t e;
    e.f = 0; e.o = 0; e.a = 0; e.b = 0; e.i = 0; e.d = 0;
    return e;
  endfunction

  function automatic exp_t ref_decode(logic [13:0] w);
    exp_t e;
    int top2;
    e = empty_exp();
    top2 = int'(w) / 4096;
    if (top2 == 0) begin
      e.f = 1; e.o = int'(w) / 256; e.d = (int'(w) / 128) % 2; e.a = int'(w) % 128;
    end else if (top2 == 1) begin
      e.f = 2; e.o = int'(w) / 1024; e.b = (int'(w) / 128) % 8; e.a = int'(w) % 128; e.d = 1;
    end else if (top2 == 2) begin
      e.f = 4; e.o = int'(w) / 2048; e.i = int'(w) % 2048;
    end else begin
      e.f = 3; e.o = int'(w) / 256; e.i = int'(w) % 256;
    end
    return e;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    string tf;
    string tr;
    if (m_flush)        tf = "R8";
    else if (m_ph != 0) tf = "R2";
    else case (m_dec.f)
      1: tf = "R4";
      2: tf = "R5";
      3: tf = "R6";
      4: tf = "R7";
      default: tf = "R11";
    endcase
    tr = (m_flush || m_ph != 0) ? tf : "R3";
    if (ctx != "") begin tf = ctx; tr = ctx; end
    chk("R1", "phase", int'(phase), m_ph);
    chk(tr, "fmt", int'(fmt), m_dec.f);
    chk(tf, "flush", int'(flush), int'(m_flush));
    chk(tf, "opcode", int'(opcode), m_dec.o);
    chk(tf, "file_addr", int'(file_addr), m_dec.a);
    chk(tf, "bit_sel", int'(bit_sel), m_dec.b);
    chk(tf, "imm", int'(imm), m_dec.i);
    chk(tf, "dest_file", int'(dest_file), m_dec.d);
  endtask

  // One clock: drive inputs, update the model at the edge, check at the falling edge.
  task automatic tick(logic [13:0] w, logic r);
    insn_word = w;
    redirect  = r;
    @(posedge clk);
    if (rst) begin
      m_ph = 0; m_flush = 1'b0; m_dec = empty_exp();
    end else begin
      if (m_ph == 3) begin
        if (m_flush) begin
          m_flush = 1'b0; m_dec = ref_decode(w);
        end else if (r) begin
          m_flush = 1'b1; m_dec = empty_exp();
        end else begin
          m_dec = ref_decode(w);
        end
      end
      m_ph = (m_ph + 1) % 4;
    end
    @(negedge clk);
    check_all();
  endtask

  // Run to the start of a phase-3 clock (phase already 3) with idle inputs.
  task automatic to_phase3();
    while (m_ph != 3) tick(insn_word, 1'b0);
  endtask

  initial begin
    m_dec = empty_exp();
    void'($urandom(32'd20240611));
    @(negedge clk);
    tick(14'h3FFF, 1'b1);
    tick(14'h1ABC, 1'b1);
    ctx = "R11";
    check_all();
    ctx = "";
    rst = 1'b0;

    // Directed formats: byte d=1, byte d=0, bit, literal, long jump.
    to_phase3(); tick(14'b00_0111_1010_1010, 1'b0);
    to_phase3(); tick(14'b00_1001_0011_0001, 1'b0);
    to_phase3(); tick(14'b01_1011_0111_1111, 1'b0);
    to_phase3(); tick(14'b11_0000_1010_0101, 1'b0);
    to_phase3(); tick(14'b10_1111_1111_1111, 1'b0);
    to_phase3(); tick(14'b10_0000_0000_0001, 1'b0);

    // R9: redirect held high in phases 0..2 only.
    ctx = "R9";
    to_phase3(); tick(14'h0055, 1'b0);
    tick(14'h0055, 1'b1); tick(14'h0055, 1'b1); tick(14'h0055, 1'b1);
    tick(14'h2345, 1'b0);
    ctx = "";

    // R8 then R10: redirect at two cycle ends in a row gives a single empty slot.
    to_phase3(); tick(14'h1111, 1'b1);
    tick(14'h1111, 1'b1); tick(14'h1111, 1'b1); tick(14'h1111, 1'b1);
    ctx = "R10";
    tick(14'h3123, 1'b1);
    ctx = "";
    tick(14'h3123, 1'b0); tick(14'h3123, 1'b0); tick(14'h3123, 1'b0);
    tick(14'h0F0F, 1'b0);

    // Random words with random redirect pulses.
    for (int n = 0; n < 3000; n++) begin
      tick(14'($urandom), ($urandom % 4) == 0);
    end

    // R11: reset in mid-run.
    to_phase3(); tick(14'h2AAA, 1'b0);
    tick(14'h2AAA, 1'b0);
    rst = 1'b1;
    tick(14'h2AAA, 1'b1);
    ctx = "R11";
    check_all();
    ctx = "";
    rst = 1'b0;
    for (int n = 0; n < 40; n++) tick(14'($urandom), ($urandom % 3) == 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule